// File: doc/BRIEF.md
# Serial Controller Register File and Interrupt Logic

This block is the register interface that a host processor sees on a 16550-style serial controller. A simple bus with one-cycle reads and writes reaches eight byte registers. The incoming address is divided by a fixed stride, so the block can sit on a bus that places registers one, two, four or eight bytes apart. The block holds these registers:

- the 16-bit baud divisor
- line control
- modem control
- interrupt enable
- first-in-first-out (FIFO) control
- a scratch byte

It reports line and modem status. From a receive-data-available flag, a transmit-ready flag and the interrupt enables, it builds the interrupt identification value and a level interrupt line.

The surrounding controller supplies a receive flag and byte, and a transmitter-idle level. It takes the following from this block:

- the transmit byte and its strobe
- the decoded frame settings (data bits, stop bits, parity, break)
- the divisor
- the interrupt line

In loopback mode, a transmitted byte is held inside the block and read back as received data. The serial shifters, the baud generator and the FIFO storage are not part of this block.

Top module: `uart_regfile`

## Requirements
- R1: The register index is the bus address divided by STRIDE. A write whose index is 8 or more changes nothing. A read whose index is 8 or more returns 0x00. Index 7 is a read/write scratch byte.
- R2: Bit 7 of the line control register (index 3) switches index 0 to the low divisor byte and index 1 to the high divisor byte, for both reads and writes. After reset the divisor is 12.
- R3: Line control bits 2:0 set the frame format. Codes 0 to 3 give 5 to 8 data bits with stop code 0 (one stop bit). Code 4 gives 5 data bits with stop code 1 (one and a half stop bits). Codes 5 to 7 give 6 to 8 data bits with stop code 2 (two stop bits).
- R4: Line control bits 5:3 set the parity output. Field 0 gives 0 (none), 1 gives 1 (odd), 3 gives 2 (even), 5 gives 3 (forced zero) and 7 gives 4 (forced one). Every other field value gives 5 (unsupported). Line control bit 6 drives the break request.
- R5: After reset the registers read as follows: line control 0x03, interrupt enable 0x00, modem control 0x00, identification 0x01. The frame outputs then show 8 data bits, no parity and one stop bit.
- R6: The line status register (index 5) ignores writes. Its bits 6 and 5 always read 1, and its bit 0 is 1 exactly while receive data is available.
- R7: The modem status register (index 6) always reads 0xB0.
- R8: The identification register (index 2) has these fields:
  - bit 2 shows that receive data is available;
  - bit 1 shows the transmit-ready flag;
  - bit 0 is 0 exactly while an interrupt is pending.

  An interrupt is pending when interrupt enable bit 1 and the transmit-ready flag are both set, or when interrupt enable bit 0 is set and receive data is available.
- R9: The interrupt output follows this rule one cycle later: it is high when an interrupt is pending and modem control bit 3 is set, and low otherwise.
- R10: A write to the interrupt enable register that takes bit 1 from 0 to 1 sets the transmit-ready flag. A write that leaves bit 1 set does not set it. Reading the identification register clears the flag.
- R11: A data write (index 0, divisor access off) sets the transmit-ready flag. Unless loopback is on, it also pulses the transmit strobe in the write cycle, with the written byte on the transmit data output. A rising edge on the transmitter-idle input also sets the flag.
- R12: With modem control bit 4 set, a data write is held as received data and the transmit strobe stays low. A data read then returns that byte and empties the hold, and no acknowledge is given.
- R13: A write to index 2 loads the FIFO control byte. With FIFO mode on, identification bits 7:6 read as FIFO control bits 2:1, and identification bits 5:3 read as zero.
- R14: With loopback off and divisor access off, a data read returns the receive byte and pulses the receive acknowledge output in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| rx_avail | input | 1 | Receive data available |
| rx_byte | input | 8 | Received byte |
| rx_ack | output | 1 | Received byte consumed by a data read |
| tx_idle | input | 1 | Transmitter idle level |
| tx_data | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | Transmit byte valid for one cycle |
| divisor | output | 16 | Baud divisor |
| data_bits | output | 4 | Data bits per frame, 5 to 8 |
| stop_code | output | 2 | 0 one, 1 one and a half, 2 two stop bits |
| parity_code | output | 3 | Parity mode code per R4 |
| break_req | output | 1 | Break requested |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:

- a read beyond index 7 returns zero;
- a divisor-low write lands in the divisor;
- the transmitter status bits are set on every line status read;
- the data-bit count stays between 5 and 8;
- a rising transmit enable arms the flag;
- the interrupt stays low whenever the modem control gate was clear.

Only the bench scenarios show the following:

- the full frame and parity code tables;
- the identification values under each combination of enables;
- clearing on an identification read;
- the loopback hold and its consumption;
- FIFO control mirroring;
- the absence of strobes or acknowledges where none are due.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = 3;

  localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
  localparam logic [IDX_W-1:0] IDX_IER  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IIR  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LCR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MCR  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_LSR  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MSR  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_SCR  = 3'd7;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4,
    PAR_BAD  = 3'd5
  } parity_e;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2
  } stop_e;

  localparam logic [7:0] LCR_RESET = 8'h03;
  localparam logic [7:0] MSR_VALUE = 8'hB0;
endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int STRIDE = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int SHIFT = $clog2(STRIDE);

  logic [ADDR_W-1:0] scaled;

  generate
    if (SHIFT == 0) begin : g_unit
      assign scaled = addr;
    end else begin : g_shift
      assign scaled = addr >> SHIFT;
    end
  endgenerate

  assign hit = (scaled < ADDR_W'(NUM_REGS));
  assign idx = scaled[IDX_W-1:0];
endmodule

// File: rtl/uart_frame_decode.sv
module uart_frame_decode
  import uart_reg_pkg::*;
(
  input  logic [7:0] lcr,
  output logic [3:0] data_bits,
  output stop_e      stop_sel,
  output parity_e    parity_sel,
  output logic       break_req,
  output logic       dlab
);
  always_comb begin
    data_bits = 4'd5 + {2'b00, lcr[1:0]};
    if (!lcr[2])             stop_sel = STOP_ONE;
    else if (lcr[1:0] == 2'd0) stop_sel = STOP_ONE_HALF;
    else                     stop_sel = STOP_TWO;
    case (lcr[5:3])
      3'd0:    parity_sel = PAR_NONE;
      3'd1:    parity_sel = PAR_ODD;
      3'd3:    parity_sel = PAR_EVEN;
      3'd5:    parity_sel = PAR_ZERO;
      3'd7:    parity_sel = PAR_ONE;
      default: parity_sel = PAR_BAD;
    endcase
  end

  assign break_req = lcr[6];
  assign dlab      = lcr[7];
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic data_wr,
  input  logic ier_wr,
  input  logic ier_wr_tx,
  input  logic tx_en,
  input  logic rx_en,
  input  logic iir_rd,
  input  logic tx_idle,
  input  logic rx_ready,
  input  logic out_gate,
  output logic tx_flag,
  output logic pending,
  output logic irq
);
  logic flag_q, flag_d;
  logic idle_q;
  logic irq_q, irq_d;
  logic arm;

  always_comb begin
    arm     = data_wr | (ier_wr & ier_wr_tx & ~tx_en) | (tx_idle & ~idle_q);
    flag_d  = flag_q;
    if (arm)         flag_d = 1'b1;
    else if (iir_rd) flag_d = 1'b0;
    pending = (tx_en & flag_q) | (rx_en & rx_ready);
    irq_d   = pending & out_gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      idle_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      idle_q <= tx_idle;
      irq_q  <= irq_d;
    end
  end

  assign tx_flag = flag_q;
  assign irq     = irq_q;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int STRIDE  = 1,
  parameter bit FIFO_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_avail,
  input  logic [7:0]        rx_byte,
  output logic              rx_ack,
  input  logic              tx_idle,
  output logic [7:0]        tx_data,
  output logic              tx_strobe,
  output logic [15:0]       divisor,
  output logic [3:0]        data_bits,
  output logic [1:0]        stop_code,
  output logic [2:0]        parity_code,
  output logic              break_req,
  output logic              irq
);
  localparam logic [15:0] DIV_RESET = 16'd12;

  logic [IDX_W-1:0] idx;
  logic             hit, wr_en, rd_en, dlab, loop_en;
  logic [7:0]       lcr_q, lcr_d, ier_q, ier_d, mcr_q, mcr_d;
  logic [7:0]       fcr_q, fcr_d, scr_q, scr_d;
  logic [15:0]      div_q, div_d;
  logic             lb_valid_q, lb_valid_d;
  logic [7:0]       lb_byte_q, lb_byte_d;
  logic             rx_ready;
  logic [7:0]       rx_sel, iir_val;
  logic             data_wr, data_rd, ier_wr, iir_rd;
  logic             tx_flag, pending;
  stop_e            stop_sel;
  parity_e          parity_sel;

  uart_addr_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) i_dec (
    .addr(bus_addr), .idx(idx), .hit(hit)
  );

  uart_frame_decode i_frame (
    .lcr(lcr_q), .data_bits(data_bits), .stop_sel(stop_sel),
    .parity_sel(parity_sel), .break_req(break_req), .dlab(dlab)
  );

  assign wr_en    = bus_wr & hit;
  assign rd_en    = bus_rd & hit;
  assign loop_en  = mcr_q[4];
  assign data_wr  = wr_en & (idx == IDX_DATA) & ~dlab;
  assign data_rd  = rd_en & (idx == IDX_DATA) & ~dlab;
  assign ier_wr   = wr_en & (idx == IDX_IER) & ~dlab;
  assign iir_rd   = rd_en & (idx == IDX_IIR);
  assign rx_ready = loop_en ? lb_valid_q : rx_avail;
  assign rx_sel   = loop_en ? lb_byte_q : rx_byte;

  uart_irq_ctrl i_irq (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ier_wr(ier_wr),
    .ier_wr_tx(bus_wdata[1]), .tx_en(ier_q[1]), .rx_en(ier_q[0]),
    .iir_rd(iir_rd), .tx_idle(tx_idle), .rx_ready(rx_ready),
    .out_gate(mcr_q[3]), .tx_flag(tx_flag), .pending(pending), .irq(irq)
  );

  // next-state logic for the host-written registers
  always_comb begin
    lcr_d      = lcr_q;
    ier_d      = ier_q;
    mcr_d      = mcr_q;
    fcr_d      = fcr_q;
    scr_d      = scr_q;
    div_d      = div_q;
    lb_valid_d = lb_valid_q;
    lb_byte_d  = lb_byte_q;
    if (wr_en) begin
      case (idx)
        IDX_DATA: if (dlab) div_d[7:0] = bus_wdata;
        IDX_IER:  if (dlab) div_d[15:8] = bus_wdata; else ier_d = bus_wdata;
        IDX_IIR:  fcr_d = bus_wdata;
        IDX_LCR:  lcr_d = bus_wdata;
        IDX_MCR:  mcr_d = bus_wdata;
        IDX_SCR:  scr_d = bus_wdata;
        default:  ;
      endcase
    end
    if (data_wr && loop_en) begin
      lb_valid_d = 1'b1;
      lb_byte_d  = bus_wdata;
    end else if (data_rd && loop_en) begin
      lb_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q      <= LCR_RESET;
      ier_q      <= 8'h00;
      mcr_q      <= 8'h00;
      fcr_q      <= 8'h00;
      scr_q      <= 8'h00;
      div_q      <= DIV_RESET;
      lb_valid_q <= 1'b0;
      lb_byte_q  <= 8'h00;
    end else begin
      lcr_q      <= lcr_d;
      ier_q      <= ier_d;
      mcr_q      <= mcr_d;
      fcr_q      <= fcr_d;
      scr_q      <= scr_d;
      div_q      <= div_d;
      lb_valid_q <= lb_valid_d;
      lb_byte_q  <= lb_byte_d;
    end
  end

  generate
    if (FIFO_EN) begin : g_fifo_id
      assign iir_val = {fcr_q[2:1], 3'b000, rx_ready, tx_flag, ~pending};
    end else begin : g_plain_id
      assign iir_val = {5'b00000, rx_ready, tx_flag, ~pending};
    end
  endgenerate

  // read mux
  always_comb begin
    bus_rdata = 8'h00;
    if (rd_en) begin
      case (idx)
        IDX_DATA: bus_rdata = dlab ? div_q[7:0] : rx_sel;
        IDX_IER:  bus_rdata = dlab ? div_q[15:8] : ier_q;
        IDX_IIR:  bus_rdata = iir_val;
        IDX_LCR:  bus_rdata = lcr_q;
        IDX_MCR:  bus_rdata = mcr_q;
        IDX_LSR:  bus_rdata = {1'b0, 2'b11, 4'b0000, rx_ready};
        IDX_MSR:  bus_rdata = MSR_VALUE;
        default:  bus_rdata = scr_q;
      endcase
    end
  end

  assign rx_ack      = data_rd & ~loop_en;
  assign tx_strobe   = data_wr & ~loop_en;
  assign tx_data     = bus_wdata;
  assign divisor     = div_q;
  assign stop_code   = stop_sel;
  assign parity_code = parity_sel;
endmodule

// File: rtl/uart_regfile_checker.sv
module uart_regfile_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       hit,
  input logic [2:0] idx,
  input logic       dlab,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [15:0] divisor,
  input logic [7:0] mcr_q,
  input logic [7:0] ier_q,
  input logic       tx_flag,
  input logic [3:0] data_bits,
  input logic       irq
);
  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |-> (bus_rdata == 8'h00));

  assert_div_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && idx == 3'd0 && dlab) |=> (divisor[7:0] == $past(bus_wdata)));

  assert_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bits >= 4'd5) && (data_bits <= 4'd8));

  assert_lsr_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit && idx == 3'd5) |-> (bus_rdata[6:5] == 2'b11));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mcr_q[3]) |-> !irq);

  assert_tx_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && idx == 3'd1 && !dlab && bus_wdata[1] && !ier_q[1]) |=> tx_flag);
endmodule

bind uart_regfile uart_regfile_checker i_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .hit(hit),
  .idx(idx), .dlab(dlab), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .divisor(divisor), .mcr_q(mcr_q), .ier_q(ier_q), .tx_flag(tx_flag),
  .data_bits(data_bits), .irq(irq)
);

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  localparam int ADDR_W = 6;
  localparam int STRIDE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_wdata = 8'h00;
  logic [7:0]        bus_rdata;
  logic              rx_avail = 1'b0;
  logic [7:0]        rx_byte = 8'h00;
  logic              rx_ack;
  logic              tx_idle = 1'b1;
  logic [7:0]        tx_data;
  logic              tx_strobe;
  logic [15:0]       divisor;
  logic [3:0]        data_bits;
  logic [1:0]        stop_code;
  logic [2:0]        parity_code;
  logic              break_req;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;
  logic       ack_seen, stb_seen;
  logic [7:0] stb_data;

  always #2 clk = ~clk;

  uart_regfile #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .FIFO_EN(1'b1)) i_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_ack(rx_ack),
    .tx_idle(tx_idle), .tx_data(tx_data), .tx_strobe(tx_strobe),
    .divisor(divisor), .data_bits(data_bits), .stop_code(stop_code),
    .parity_code(parity_code), .break_req(break_req), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = ADDR_W'(idx * STRIDE);
    bus_wdata = d;
    bus_wr    = 1'b1;
    #1;
    stb_seen = tx_strobe;
    stb_data = tx_data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int idx, output logic [7:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(idx * STRIDE);
    bus_rd   = 1'b1;
    #1;
    d        = bus_rdata;
    ack_seen = rx_ack;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd_reg(3, rv); check(rv == 8'h03, "R5 lcr", rv, 8'h03);
    rd_reg(1, rv); check(rv == 8'h00, "R5 ier", rv, 8'h00);
    rd_reg(4, rv); check(rv == 8'h00, "R5 mcr", rv, 8'h00);
    rd_reg(2, rv); check(rv == 8'h01, "R5 iir", rv, 8'h01);
    check(data_bits == 4'd8 && parity_code == 3'd0 && stop_code == 2'd0,
          "R5 frame", {data_bits, 1'b0, parity_code, 2'b0, stop_code}, 12'h800);
    check(irq == 1'b0, "R5 irq", irq, 0);
  endtask

  task automatic t_divisor();
    check(divisor == 16'd12, "R2 reset divisor", divisor, 12);
    wr_reg(3, 8'h83);
    rd_reg(0, rv); check(rv == 8'd12, "R2 div low read", rv, 12);
    rd_reg(1, rv); check(rv == 8'd0, "R2 div high read", rv, 0);
    wr_reg(0, 8'h34);
    check(stb_seen == 1'b0, "R2 no strobe on divisor write", stb_seen, 0);
    wr_reg(1, 8'h12);
    check(divisor == 16'h1234, "R2 divisor value", divisor, 16'h1234);
    wr_reg(3, 8'h03);
    rd_reg(1, rv); check(rv == 8'h00, "R2 ier after dlab clear", rv, 0);
  endtask

  task automatic t_frame();
    for (int c = 0; c < 8; c++) begin
      logic [3:0] eb;
      logic [1:0] es;
      eb = 4'(5 + (c % 4));
      es = (c < 4) ? 2'd0 : ((c == 4) ? 2'd1 : 2'd2);
      wr_reg(3, 8'(c));
      check(data_bits == eb, "R3 data bits", data_bits, eb);
      check(stop_code == es, "R3 stop code", stop_code, es);
    end
  endtask

  task automatic t_parity();
    logic [2:0] exp_tab [8];
    exp_tab = '{3'd0, 3'd1, 3'd5, 3'd2, 3'd5, 3'd3, 3'd5, 3'd4};
    for (int p = 0; p < 8; p++) begin
      wr_reg(3, 8'(8'h03 | (p << 3)));
      check(parity_code == exp_tab[p], "R4 parity", parity_code, exp_tab[p]);
    end
    check(break_req == 1'b0, "R4 no break", break_req, 0);
    wr_reg(3, 8'h43);
    check(break_req == 1'b1, "R4 break", break_req, 1);
    wr_reg(3, 8'h03);
  endtask

  task automatic t_status();
    rx_avail = 1'b0;
    rd_reg(5, rv); check(rv == 8'h60, "R6 lsr idle", rv, 8'h60);
    rx_avail = 1'b1;
    rd_reg(5, rv); check(rv == 8'h61, "R6 lsr rx", rv, 8'h61);
    wr_reg(5, 8'h00);
    rd_reg(5, rv); check(rv == 8'h61, "R6 lsr write ignored", rv, 8'h61);
    rd_reg(6, rv); check(rv == 8'hB0, "R7 msr", rv, 8'hB0);
    rx_avail = 1'b0;
  endtask

  task automatic t_rx_read();
    rx_avail = 1'b1; rx_byte = 8'h5A;
    rd_reg(0, rv);
    check(rv == 8'h5A, "R14 rx byte", rv, 8'h5A);
    check(ack_seen == 1'b1, "R14 rx ack", ack_seen, 1);
    rd_reg(7, rv);
    check(ack_seen == 1'b0, "R14 no ack on scratch", ack_seen, 0);
    rx_avail = 1'b0;
  endtask

  task automatic t_rx_irq();
    rx_avail = 1'b1;
    wr_reg(1, 8'h01);
    rd_reg(2, rv); check(rv == 8'hC4 || rv == 8'h04, "R8 iir rx pending", rv, 8'h04);
    settle();
    check(irq == 1'b0, "R9 irq gated", irq, 0);
    wr_reg(4, 8'h08);
    settle();
    check(irq == 1'b1, "R9 irq asserted", irq, 1);
    rx_avail = 1'b0;
    settle();
    check(irq == 1'b0, "R9 irq released", irq, 0);
    rd_reg(2, rv); check(rv == 8'h01, "R8 iir none", rv, 8'h01);
  endtask

  task automatic t_tx_rearm();
    wr_reg(1, 8'h02);
    rd_reg(2, rv); check(rv == 8'h02, "R10 rise sets flag", rv, 8'h02);
    check(irq == 1'b1, "R9 irq on tx", irq, 1);
    rd_reg(2, rv); check(rv == 8'h01, "R10 read clears", rv, 8'h01);
    settle();
    check(irq == 1'b0, "R9 irq off after clear", irq, 0);
    wr_reg(1, 8'h02);
    rd_reg(2, rv); check(rv == 8'h01, "R10 no rise no set", rv, 8'h01);
    wr_reg(1, 8'h00);
    wr_reg(1, 8'h02);
    rd_reg(2, rv); check(rv == 8'h02, "R10 second rise", rv, 8'h02);
  endtask

  task automatic t_tx_write();
    wr_reg(0, 8'h41);
    check(stb_seen == 1'b1, "R11 strobe", stb_seen, 1);
    check(stb_data == 8'h41, "R11 tx data", stb_data, 8'h41);
    rd_reg(2, rv); check(rv == 8'h02, "R11 write sets flag", rv, 8'h02);
    tx_idle = 1'b0;
    settle();
    rd_reg(2, rv); check(rv == 8'h01, "R11 no set on idle fall", rv, 8'h01);
    tx_idle = 1'b1;
    settle();
    rd_reg(2, rv); check(rv == 8'h02, "R11 idle rise sets flag", rv, 8'h02);
  endtask

  task automatic t_loopback();
    wr_reg(4, 8'h18);
    wr_reg(0, 8'h77);
    check(stb_seen == 1'b0, "R12 no strobe", stb_seen, 0);
    rd_reg(5, rv); check(rv == 8'h61, "R12 held byte ready", rv, 8'h61);
    rd_reg(0, rv);
    check(rv == 8'h77, "R12 byte returned", rv, 8'h77);
    check(ack_seen == 1'b0, "R12 no ack", ack_seen, 0);
    rd_reg(5, rv); check(rv == 8'h60, "R12 hold emptied", rv, 8'h60);
    wr_reg(4, 8'h08);
  endtask

  task automatic t_fifo_id();
    wr_reg(2, 8'h06);
    rd_reg(2, rv);
    rd_reg(2, rv); check(rv == 8'hC1, "R13 iir fifo bits", rv, 8'hC1);
    wr_reg(2, 8'h02);
    rd_reg(2, rv); check(rv == 8'h41, "R13 iir one bit", rv, 8'h41);
    wr_reg(2, 8'h00);
  endtask

  task automatic t_stride();
    wr_reg(7, 8'hA5);
    rd_reg(7, rv); check(rv == 8'hA5, "R1 scratch", rv, 8'hA5);
    wr_reg(8, 8'h99);
    check(stb_seen == 1'b0, "R1 out of range no strobe", stb_seen, 0);
    rd_reg(8, rv); check(rv == 8'h00, "R1 out of range reads zero", rv, 0);
    rd_reg(7, rv); check(rv == 8'hA5, "R1 scratch untouched", rv, 8'hA5);
    rd_reg(0, rv); check(ack_seen == 1'b1, "R1 index 0 alive", ack_seen, 1);
    @(negedge clk);
    bus_addr = ADDR_W'(7 * STRIDE + 3);
    bus_rd = 1'b1;
    #1 check(bus_rdata == 8'hA5, "R1 low address bits dropped", bus_rdata, 8'hA5);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divisor();
        t_frame();
        t_parity();
        t_status();
        t_rx_read();
        t_rx_irq();
        t_tx_rearm();
        t_tx_write();
        t_loopback();
        t_fifo_id();
        t_stride();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule